// File: doc/BRIEF.md
# Packed SIMD Integer Lane Unit

This block is a registered datapath for packed integer arithmetic on two 64-bit operands. The operands are split into eight byte lanes or four 16-bit word lanes, and every lane is processed in parallel. The block offers these operations:

- wrapping add and subtract
- unsigned saturating add and subtract
- a butterfly that returns the sum and the difference together
- signed and unsigned minimum and maximum
- compares that yield all-ones or all-zero lane masks
- an unsigned byte average that rounds up
- a pack that narrows signed words to unsigned bytes with clamping

An operation is issued by raising `in_valid` with an opcode, a lane-size select and the two operands. Exactly one cycle later the block raises `res_valid` and presents the primary result. During a butterfly it also presents a second result. Results stay on the outputs until the next issued operation. The block has no condition flags.

Top module: `simd_lane_alu`

## Requirements
- R1: While reset is active and after it is released with no issue, `res_valid` is 0 and both `res_lo` and `res_hi` are 0.
- R2: An operation issued with `in_valid` high at a clock edge produces `res_valid` high after that edge for exactly one cycle. If `in_valid` is low, `res_valid` drops and `res_lo` and `res_hi` keep their previous values.
- R3: `lane_word` = 0 selects eight byte lanes and 1 selects four word lanes. Lane i of a value occupies bits [i*L+L-1 : i*L], where L is the lane width. Add (opcode 0) gives b+a per lane and subtract (opcode 1) gives b-a per lane, both wrapping modulo 2^L.
- R4: Saturating add (opcode 2) gives b+a clamped to 2^L-1. Saturating subtract (opcode 3) gives b-a clamped to 0. Both treat the lanes as unsigned.
- R5: Butterfly (opcode 4) puts the wrapping b+a on `res_lo` and the wrapping b-a on `res_hi`. For every other opcode `res_hi` is 0.
- R6: Unsigned min (5) and unsigned max (6) pick per lane between a and b. Signed min (7) and signed max (8) do the same with two's-complement lanes.
- R7: Compares test b against a per lane: equal (9), unsigned greater (10), signed greater (11) and signed greater-or-equal (12). A true lane becomes all ones and a false lane becomes all zeros.
- R8: Average (13) always works on byte lanes and gives (a+b+1)>>1 unsigned. `lane_word` has no effect on it.
- R9: Pack (14) treats each 16-bit lane as signed. It clamps negative values to 0x00 and values above 255 to 0xff. Result byte i (i<4) comes from word i of b, and byte i+4 comes from word i of a. `lane_word` has no effect on it.
- R10: Opcode 15 gives 0 on both `res_lo` and `res_hi`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Issue strobe |
| op | input | 4 | Operation code |
| lane_word | input | 1 | 0 = byte lanes, 1 = word lanes |
| opnd_a | input | 64 | First operand |
| opnd_b | input | 64 | Second operand |
| res_valid | output | 1 | Result valid, one cycle after issue |
| res_lo | output | 64 | Primary result |
| res_hi | output | 64 | Butterfly difference, otherwise 0 |

## Verification
The bench builds the block with its default `DATA_W` of 64, which gives eight byte lanes and four word lanes. This width puts the pack's split between the two operands and the upper lanes of every operation within reach. Short directed vectors place known values in the low half and leave the upper lanes at zero. These vectors exercise carries that cross a lane boundary without spilling, the equal-lane case of each compare, and negative pack inputs. Random operands cover every opcode in both lane sizes, including the reserved code.

// File: rtl/simd_pkg.sv
package simd_pkg;

  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,
    OP_SUB   = 4'd1,
    OP_ADDUS = 4'd2,
    OP_SUBUS = 4'd3,
    OP_BFLY  = 4'd4,
    OP_MINU  = 4'd5,
    OP_MAXU  = 4'd6,
    OP_MINS  = 4'd7,
    OP_MAXS  = 4'd8,
    OP_CMPEQ = 4'd9,
    OP_CMPHI = 4'd10,
    OP_CMPGT = 4'd11,
    OP_CMPGE = 4'd12,
    OP_AVG   = 4'd13,
    OP_PACK  = 4'd14,
    OP_RSVD  = 4'd15
  } simd_op_e;

  // Clamp a signed 16-bit value into the unsigned byte range
  function automatic logic [7:0] clamp_s16_to_u8(input logic [15:0] w);
    if (w[15])        return 8'h00;
    else if (|w[14:8]) return 8'hff;
    else              return w[7:0];
  endfunction

  // Rounded-up unsigned mean of two bytes
  function automatic logic [7:0] mean_up_u8(input logic [7:0] x, input logic [7:0] y);
    logic [8:0] s;
    s = {1'b0, x} + {1'b0, y} + 9'd1;
    return s[8:1];
  endfunction

  // True when every lane of v is either all ones or all zeros
  function automatic logic lanes_are_masks(input logic [63:0] v, input logic word);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < 8; i++) begin
      if (!word && v[i*8 +: 8] != 8'h00 && v[i*8 +: 8] != 8'hff) ok = 1'b0;
    end
    for (int i = 0; i < 4; i++) begin
      if (word && v[i*16 +: 16] != 16'h0000 && v[i*16 +: 16] != 16'hffff) ok = 1'b0;
    end
    return ok;
  endfunction

  // True when every byte of x is unsigned >= the matching byte of y
  function automatic logic bytes_not_below(input logic [63:0] x, input logic [63:0] y);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < 8; i++) begin
      if (x[i*8 +: 8] < y[i*8 +: 8]) ok = 1'b0;
    end
    return ok;
  endfunction

endpackage

// File: rtl/simd_lane.sv
module simd_lane
  import simd_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] r_main,
  output logic [W-1:0] r_aux
);

  localparam logic [W-1:0] ALL1 = {W{1'b1}};
  localparam logic [W-1:0] ALL0 = {W{1'b0}};

  logic [W:0] sum_x;
  logic [W:0] dif_x;
  logic       carry_out;
  logic       borrow_out;
  logic       b_gt_u;
  logic       b_gt_s;
  logic       b_eq;

  assign sum_x      = {1'b0, b} + {1'b0, a};
  assign dif_x      = {1'b0, b} - {1'b0, a};
  assign carry_out  = sum_x[W];
  assign borrow_out = dif_x[W];
  assign b_eq       = (b == a);
  assign b_gt_u     = (b > a);
  assign b_gt_s     = ($signed(b) > $signed(a));

  always_comb begin
    r_aux = ALL0;
    case (simd_op_e'(op))
      OP_ADD:   r_main = sum_x[W-1:0];
      OP_SUB:   r_main = dif_x[W-1:0];
      OP_ADDUS: r_main = carry_out ? ALL1 : sum_x[W-1:0];
      OP_SUBUS: r_main = borrow_out ? ALL0 : dif_x[W-1:0];
      OP_BFLY: begin
        r_main = sum_x[W-1:0];
        r_aux  = dif_x[W-1:0];
      end
      OP_MINU:  r_main = b_gt_u ? a : b;
      OP_MAXU:  r_main = b_gt_u ? b : a;
      OP_MINS:  r_main = b_gt_s ? a : b;
      OP_MAXS:  r_main = b_gt_s ? b : a;
      OP_CMPEQ: r_main = b_eq ? ALL1 : ALL0;
      OP_CMPHI: r_main = b_gt_u ? ALL1 : ALL0;
      OP_CMPGT: r_main = b_gt_s ? ALL1 : ALL0;
      OP_CMPGE: r_main = (b_gt_s || b_eq) ? ALL1 : ALL0;
      default:  r_main = ALL0;
    endcase
  end

endmodule

// File: rtl/simd_shape.sv
module simd_shape
  import simd_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] avg_res,
  output logic [DATA_W-1:0] pack_res
);

  localparam int NB   = DATA_W / 8;
  localparam int NW   = DATA_W / 16;

  for (genvar i = 0; i < NB; i++) begin : g_avg
    assign avg_res[i*8 +: 8] = mean_up_u8(a[i*8 +: 8], b[i*8 +: 8]);
  end

  // Low half of the packed result comes from b, high half from a
  for (genvar i = 0; i < NW; i++) begin : g_pack
    assign pack_res[i*8 +: 8]        = clamp_s16_to_u8(b[i*16 +: 16]);
    assign pack_res[(i+NW)*8 +: 8]   = clamp_s16_to_u8(a[i*16 +: 16]);
  end

endmodule

// File: rtl/simd_lane_alu.sv
module simd_lane_alu
  import simd_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [3:0]        op,
  input  logic              lane_word,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_lo,
  output logic [DATA_W-1:0] res_hi
);

  localparam int NB = DATA_W / 8;
  localparam int NW = DATA_W / 16;

  logic [DATA_W-1:0] byte_main, byte_aux;
  logic [DATA_W-1:0] word_main, word_aux;
  logic [DATA_W-1:0] avg_res, pack_res;
  logic [DATA_W-1:0] next_lo, next_hi;
  logic [3:0]        op_q;
  logic              word_q;

  for (genvar i = 0; i < NB; i++) begin : g_byte
    simd_lane #(.W(8)) u_lane (
      .op    (op),
      .a     (opnd_a[i*8 +: 8]),
      .b     (opnd_b[i*8 +: 8]),
      .r_main(byte_main[i*8 +: 8]),
      .r_aux (byte_aux[i*8 +: 8])
    );
  end

  for (genvar i = 0; i < NW; i++) begin : g_word
    simd_lane #(.W(16)) u_lane (
      .op    (op),
      .a     (opnd_a[i*16 +: 16]),
      .b     (opnd_b[i*16 +: 16]),
      .r_main(word_main[i*16 +: 16]),
      .r_aux (word_aux[i*16 +: 16])
    );
  end

  simd_shape #(.DATA_W(DATA_W)) u_shape (
    .a       (opnd_a),
    .b       (opnd_b),
    .avg_res (avg_res),
    .pack_res(pack_res)
  );

  always_comb begin
    case (simd_op_e'(op))
      OP_AVG: begin
        next_lo = avg_res;
        next_hi = '0;
      end
      OP_PACK: begin
        next_lo = pack_res;
        next_hi = '0;
      end
      default: begin
        next_lo = lane_word ? word_main : byte_main;
        next_hi = lane_word ? word_aux  : byte_aux;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_lo    <= '0;
      res_hi    <= '0;
      op_q      <= 4'd0;
      word_q    <= 1'b0;
    end else begin
      res_valid <= in_valid;
      if (in_valid) begin
        res_lo <= next_lo;
        res_hi <= next_hi;
        op_q   <= op;
        word_q <= lane_word;
      end
    end
  end

  // Observation wires for the checks below
  logic done_cmp, done_addus_b, done_other;
  assign done_cmp     = res_valid && (op_q >= OP_CMPEQ) && (op_q <= OP_CMPGE);
  assign done_addus_b = res_valid && (op_q == OP_ADDUS) && !word_q;
  assign done_other   = res_valid && (op_q != OP_BFLY);

  a_r2_issue_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> res_valid);
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!res_valid && $stable(res_lo) && $stable(res_hi)));
  a_r7_mask_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    done_cmp |-> lanes_are_masks(res_lo, word_q));
  a_r4_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    done_addus_b |-> bytes_not_below(res_lo, $past(opnd_b)));
  a_r5_aux_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done_other |-> (res_hi == '0));

endmodule

// File: tb/test_simd_lane_alu.sv
module test_simd_lane_alu;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [3:0]  op = 4'd0;
  logic        lane_word = 1'b0;
  logic [63:0] opnd_a = '0;
  logic [63:0] opnd_b = '0;
  logic        res_valid;
  logic [63:0] res_lo, res_hi;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  simd_lane_alu i_simd_lane_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .lane_word(lane_word),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .res_valid(res_valid), .res_lo(res_lo), .res_hi(res_hi)
  );

  // Independent model: integer arithmetic lane by lane
  function automatic void model(input logic [3:0] o, input logic w, input logic [63:0] a,
                                input logic [63:0] b, output logic [63:0] lo, output logic [63:0] hi);
    longint lw, n, full, ua, ub, sa, sb, r, d;
    lo = '0; hi = '0;
    if (o == 4'd13) begin
      for (int i = 0; i < 8; i++) begin
        ua = longint'(a[i*8 +: 8]); ub = longint'(b[i*8 +: 8]);
        lo[i*8 +: 8] = 8'((ua + ub + 1) / 2);
      end
      return;
    end
    if (o == 4'd14) begin
      for (int i = 0; i < 8; i++) begin
        sa = (i < 4) ? longint'($signed(b[i*16 +: 16])) : longint'($signed(a[(i-4)*16 +: 16]));
        r  = (sa < 0) ? 0 : (sa > 255 ? 255 : sa);
        lo[i*8 +: 8] = 8'(r);
      end
      return;
    end
    lw = w ? 16 : 8; n = 64 / lw; full = (longint'(1) << lw);
    for (int i = 0; i < n; i++) begin
      ua = longint'((a >> (i*lw)) & 64'(full-1));
      ub = longint'((b >> (i*lw)) & 64'(full-1));
      sa = (ua >= full/2) ? ua - full : ua;
      sb = (ub >= full/2) ? ub - full : ub;
      d = 0;
      case (o)
        4'd0: r = ub + ua;
        4'd1: r = ub - ua;
        4'd2: r = (ub + ua > full-1) ? full-1 : ub + ua;
        4'd3: r = (ub < ua) ? 0 : ub - ua;
        4'd4: begin r = ub + ua; d = ub - ua; end
        4'd5: r = (ua < ub) ? ua : ub;
        4'd6: r = (ua > ub) ? ua : ub;
        4'd7: r = (sa < sb) ? sa : sb;
        4'd8: r = (sa > sb) ? sa : sb;
        4'd9: r = (ub == ua) ? -1 : 0;
        4'd10: r = (ub > ua) ? -1 : 0;
        4'd11: r = (sb > sa) ? -1 : 0;
        4'd12: r = (sb >= sa) ? -1 : 0;
        default: r = 0;
      endcase
      lo = lo | ((64'(r) & 64'(full-1)) << (i*lw));
      hi = hi | ((64'(d) & 64'(full-1)) << (i*lw));
    end
  endfunction

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  // Issue one op, check both outputs one cycle later
  task automatic run(input string req, input logic [3:0] o, input logic w,
                     input logic [63:0] a, input logic [63:0] b,
                     input logic [63:0] elo, input logic [63:0] ehi);
    @(negedge clk);
    in_valid = 1'b1; op = o; lane_word = w; opnd_a = a; opnd_b = b;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " valid"}, {63'd0, res_valid}, 64'd1);
    check({req, " lo"}, res_lo, elo);
    check({req, " hi"}, res_hi, ehi);
  endtask

  task automatic run_model(input string req, input logic [3:0] o, input logic w,
                           input logic [63:0] a, input logic [63:0] b);
    logic [63:0] elo, ehi;
    model(o, w, a, b, elo, ehi);
    run(req, o, w, a, b, elo, ehi);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] keep_lo;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R1 reset valid", {63'd0, res_valid}, 64'd0);
    check("R1 reset lo", res_lo, 64'd0);
    check("R1 reset hi", res_hi, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", {63'd0, res_valid}, 64'd0);

    // Directed corner cases
    run("R5 byte butterfly", 4'd4, 1'b0, 64'h01038081, 64'h44028183, 64'h45050104, 64'h43ff0102);
    run("R5 word butterfly", 4'd4, 1'b1, 64'h01038081, 64'h44028183, 64'h45050204, 64'h42ff0102);
    run("R7 cmp eq", 4'd9,  1'b0, 64'h0, 64'h01ff0083, 64'hffffffff0000ff00, 64'h0);
    run("R7 cmp hi", 4'd10, 1'b0, 64'h0, 64'h01ff0083, 64'h00000000ffff00ff, 64'h0);
    run("R7 cmp gt", 4'd11, 1'b0, 64'h0, 64'h01ff0083, 64'h00000000ff000000, 64'h0);
    run("R7 cmp ge", 4'd12, 1'b0, 64'h0, 64'h01ff0083, 64'hffffffffff00ff00, 64'h0);
    run("R8 avg", 4'd13, 1'b0, 64'h0123fe01, 64'h0424fd70, 64'h0324fe39, 64'h0);
    run("R8 avg word select ignored", 4'd13, 1'b1, 64'h0123fe01, 64'h0424fd70, 64'h0324fe39, 64'h0);
    run("R6 signed byte min", 4'd7, 1'b0, 64'h123460cd, 64'h4321ab70, 64'h1221abcd, 64'h0);
    run("R9 pack", 4'd14, 1'b0, 64'h0, 64'h008012340044fffd, 64'h0000000080ff4400, 64'h0);
    run("R9 pack a half", 4'd14, 1'b1, 64'h7fff8000000100ff, 64'h0, 64'hff0001ff00000000, 64'h0);
    run("R4 sat add clamp", 4'd2, 1'b0, 64'h80, 64'h90, 64'hff, 64'h0);
    run("R4 sat sub floor", 4'd3, 1'b1, 64'h0005, 64'h0003, 64'h0, 64'h0);
    run("R3 wrap add word", 4'd0, 1'b1, 64'h0001, 64'hffff, 64'h0, 64'h0);
    run("R3 wrap sub byte", 4'd1, 1'b0, 64'h01, 64'h00, 64'hff, 64'h0);
    run("R10 reserved op", 4'd15, 1'b0, 64'hffffffffffffffff, 64'h1234, 64'h0, 64'h0);

    // R2: outputs hold while idle
    keep_lo = res_lo;
    run("R2 issue", 4'd0, 1'b0, 64'h0101010101010101, 64'h0202020202020202, 64'h0303030303030303, 64'h0);
    keep_lo = res_lo;
    @(negedge clk);
    check("R2 valid drops", {63'd0, res_valid}, 64'd0);
    check("R2 lo holds", res_lo, keep_lo);

    // Random sweep over all opcodes and both lane sizes (R3..R10)
    for (int k = 0; k < 400; k++) begin
      logic [63:0] ra, rb;
      ra = {$urandom, $urandom};
      rb = {$urandom, $urandom};
      if (k % 5 == 0) rb = ra;
      run_model("R3-R10 random", 4'(k % 16), 1'(k / 16), ra, rb);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule